// File: doc/BRIEF.md
# Delayed-Write Processor State Register Unit

This block owns a processor's special state registers: the multiply/divide helper register Y, the processor status register PSR, the window-invalid mask WIM, the trap-base register TBR, and a small bank of ancillary state registers selected by an index. Each cycle in which the issue strobe is high, it takes one operation. Reads return the committed value of the selected register one cycle later. Writes store the bitwise XOR of the two source operands. A write does not take effect at once. It enters a short shift pipeline that advances only when an instruction issues, and it commits three issued instructions later.

Accesses to any register other than Y need supervisor mode. Undefined operation codes, and ancillary indices that have no register behind them, raise an illegal-instruction trap. A trapped operation changes nothing. Software that needs a written value to be visible follows the write with three filler instructions (NOPs) before it reads.

Top module: `state_reg_unit`

## Requirements
- R1: A write stores `src_a ^ src_b` into the target register.
- R2: A write issued as instruction N commits at the clock edge of instruction N+3. Reads issued as N+1, N+2 or N+3 return the old value, and a read issued as N+4 returns the new one. Cycles with `issue` low do not advance pending writes.
- R3: `op` encoding: bit 3 set means write and clear means read. Bits 2:0 select the target: 1=Y, 2=PSR, 3=WIM, 4=TBR, 5=ancillary register `asr_idx`. All ten read/write codes reach their own register.
- R4: Y may be read and written in either mode. Any other target issued with `supervisor`=0 raises `trap_priv`.
- R5: Codes 6, 7, 8, 14 and 15 (15 is the unimplemented instruction) raise `trap_illegal` in either mode.
- R6: A read that does not trap drives `rd_valid`=1 and the register value on `rd_data` in the cycle after issue. In every other cycle `rd_valid`=0 and `rd_data`=0.
- R7: An ancillary access with `asr_idx` >= NUM_ASR (4 by default) raises `trap_illegal`.
- R8: A trapped operation writes nothing, adds nothing to the write pipeline and gives no read data. Writes already pending still advance and commit.
- R9: A synchronous active-low reset clears every register and every pending write. After reset PSR reads 0x0000_0080 (the supervisor bit, bit 7) and all other registers read 0.
- R10: When an operation is both illegal and privileged, only `trap_illegal` is raised. The two traps never occur together.
- R11: Code 0 (NOP) raises no trap, reads and writes nothing, and counts as an issued instruction for R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | One operation issues this cycle |
| op | input | 4 | Operation code (see R3, R5, R11) |
| asr_idx | input | 5 | Ancillary register index |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second operand (register or immediate) |
| supervisor | input | 1 | 1 = supervisor mode |
| rd_data | output | 32 | Read result, one cycle after issue |
| rd_valid | output | 1 | rd_data carries a read result |
| trap_priv | output | 1 | Privileged-instruction trap, one cycle after issue |
| trap_illegal | output | 1 | Illegal-instruction trap, one cycle after issue |

## Verification
The bench runs every opcode in both modes over in-range and out-of-range ancillary indices, and checks each result against an arithmetic model of the register file and its three pending slots. The hardest cases are the delay edges. A read three instructions after a write must still see the old value, and idle cycles inside that window must not advance it. A design with an off-by-one pipe, or one that forwards pending data, would return the new value too early. A design that advances on every clock would commit during the gaps. The bench also covers a trapped write wedged between pending writes, user-mode Y access, the illegal-over-privileged priority, and a reset with writes in flight. Wrong handling there shows up as a corrupted register, a stray trap or stale data surviving the reset.

// File: rtl/srg_pkg.sv
// Package: shared operation codes and target encoding for the state
// register unit. Assumes a 4-bit operation code, with bit 3 as the
// write flag and bits 2:0 as the target selector.
package srg_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        TGT_Y   = 3'd0,
        TGT_PSR = 3'd1,
        TGT_WIM = 3'd2,
        TGT_TBR = 3'd3,
        TGT_ASR = 3'd4
    } tgt_e;

    localparam logic [3:0] OP_NOP    = 4'd0;
    localparam logic [3:0] OP_RD_Y   = 4'd1;
    localparam logic [3:0] OP_WR_Y   = 4'd9;
    localparam logic [3:0] OP_UNIMP  = 4'd15;

    localparam logic [DATA_W-1:0] PSR_RESET = 32'h0000_0080;

endpackage

// File: rtl/srg_decode.sv
// Module: srg_decode
// Purely combinational decode of one issued operation into read/write
// intent, target, and trap conditions. Assumes NUM_ASR <= 2**IDX_W.
// Illegal traps take priority; privilege is only checked on legal ops.
module srg_decode
    import srg_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_ASR = 4
) (
    input  logic [3:0]       op,
    input  logic [IDX_W-1:0] idx,
    input  logic             supervisor,
    output logic             is_read,
    output logic             is_write,
    output tgt_e             tgt,
    output logic             trap_priv,
    output logic             trap_illegal
);
    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(NUM_ASR);

    logic [2:0] sel;
    logic       is_nop;
    logic       sel_ok;
    logic       idx_bad;

    // Classify the opcode and derive both trap conditions.
    always_comb begin
        sel          = op[2:0];
        is_nop       = (op == OP_NOP);
        sel_ok       = (sel >= 3'd1) && (sel <= 3'd5);
        idx_bad      = (sel == 3'd5) && ({1'b0, idx} >= IDX_LIMIT);
        trap_illegal = !is_nop && (!sel_ok || idx_bad);
        trap_priv    = !is_nop && !trap_illegal && !supervisor && (sel != 3'd1);
        is_read      = sel_ok && !op[3];
        is_write     = sel_ok && op[3];
        tgt          = sel_ok ? tgt_e'(sel - 3'd1) : TGT_Y;
    end

endmodule

// File: rtl/srg_wpipe.sv
// Module: srg_wpipe
// Fixed-depth shift pipeline for pending writes. It advances one stage
// per issued instruction and presents the entry that leaves the last
// stage as a commit. Assumes DEPTH >= 1 and that the caller only pushes
// legal, untrapped writes.
module srg_wpipe
    import srg_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int IDX_W = 5,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             push,
    input  tgt_e             push_tgt,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [DW-1:0]    push_data,
    output logic             commit,
    output tgt_e             commit_tgt,
    output logic [IDX_W-1:0] commit_idx,
    output logic [DW-1:0]    commit_data,
    output logic [DEPTH-1:0] stage_valid
);
    logic             v_q   [DEPTH];
    tgt_e             t_q   [DEPTH];
    logic [IDX_W-1:0] i_q   [DEPTH];
    logic [DW-1:0]    d_q   [DEPTH];

    // Stage 0 captures the new write on each issued instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q[0] <= 1'b0;
            t_q[0] <= TGT_Y;
            i_q[0] <= '0;
            d_q[0] <= '0;
        end else if (advance) begin
            v_q[0] <= push;
            t_q[0] <= push_tgt;
            i_q[0] <= push_idx;
            d_q[0] <= push_data;
        end
    end

    genvar s;
    generate
        for (s = 1; s < DEPTH; s++) begin : g_stage
            // Later stages shift from their predecessor on each issue.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[s] <= 1'b0;
                    t_q[s] <= TGT_Y;
                    i_q[s] <= '0;
                    d_q[s] <= '0;
                end else if (advance) begin
                    v_q[s] <= v_q[s-1];
                    t_q[s] <= t_q[s-1];
                    i_q[s] <= i_q[s-1];
                    d_q[s] <= d_q[s-1];
                end
            end
        end
        for (s = 0; s < DEPTH; s++) begin : g_vout
            assign stage_valid[s] = v_q[s];
            // A stage never changes while no instruction issues.
            assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !advance |=> $stable(v_q[s]) && $stable(d_q[s]));
        end
    endgenerate

    // Commit is the last stage leaving on an issued instruction.
    always_comb begin
        commit      = advance && v_q[DEPTH-1];
        commit_tgt  = t_q[DEPTH-1];
        commit_idx  = i_q[DEPTH-1];
        commit_data = d_q[DEPTH-1];
    end

endmodule

// File: rtl/srg_bank.sv
// Module: srg_bank
// Storage for Y, PSR, WIM, TBR and NUM_ASR ancillary registers, with one
// commit port and one combinational read port. Assumes NUM_ASR is a power
// of two of at least 2, and that out-of-range indices are trapped upstream.
module srg_bank
    import srg_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_ASR = 4,
    parameter int DW      = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  tgt_e             wr_tgt,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  tgt_e             rd_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    localparam int AW = $clog2(NUM_ASR);

    logic [DW-1:0] y_q, psr_q, wim_q, tbr_q;
    logic [DW-1:0] asr_q [NUM_ASR];

    // Architectural registers update on a matching commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q   <= '0;
            psr_q <= PSR_RESET;
            wim_q <= '0;
            tbr_q <= '0;
        end else if (wr_en) begin
            if (wr_tgt == TGT_Y)   y_q   <= wr_data;
            if (wr_tgt == TGT_PSR) psr_q <= wr_data;
            if (wr_tgt == TGT_WIM) wim_q <= wr_data;
            if (wr_tgt == TGT_TBR) tbr_q <= wr_data;
        end
    end

    genvar a;
    generate
        for (a = 0; a < NUM_ASR; a++) begin : g_asr
            // Each ancillary register updates on a commit to its index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    asr_q[a] <= '0;
                else if (wr_en && wr_tgt == TGT_ASR && wr_idx == IDX_W'(a))
                    asr_q[a] <= wr_data;
            end
        end
    endgenerate

    // Select the committed value of the requested register.
    always_comb begin
        unique case (rd_tgt)
            TGT_Y:   rd_data = y_q;
            TGT_PSR: rd_data = psr_q;
            TGT_WIM: rd_data = wim_q;
            TGT_TBR: rd_data = tbr_q;
            TGT_ASR: rd_data = asr_q[rd_idx[AW-1:0]];
            default: rd_data = '0;
        endcase
    end

    // PSR leaves reset with only the supervisor bit set.
    assert_psr_reset_R9: assert property (@(posedge clk)
        !rst_n |=> psr_q == PSR_RESET);

endmodule

// File: rtl/state_reg_unit.sv
// Module: state_reg_unit (top)
// Executes reads and delayed XOR writes of the processor state registers,
// with privilege and legality traps. Results and traps are registered and
// appear one cycle after issue. Assumes at most one issue per cycle.
module state_reg_unit
    import srg_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_ASR = 4,
    parameter int DELAY   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        op,
    input  logic [IDX_W-1:0]  asr_idx,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              supervisor,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              trap_priv,
    output logic              trap_illegal
);
    logic              dec_rd, dec_wr, dec_priv, dec_ill, trapped;
    tgt_e              dec_tgt;
    logic              cm_en;
    tgt_e              cm_tgt;
    logic [IDX_W-1:0]  cm_idx;
    logic [DATA_W-1:0] cm_data, bank_rd;
    logic [DELAY-1:0]  pend_v;

    srg_decode #(.IDX_W(IDX_W), .NUM_ASR(NUM_ASR)) u_dec (
        .op(op), .idx(asr_idx), .supervisor(supervisor),
        .is_read(dec_rd), .is_write(dec_wr), .tgt(dec_tgt),
        .trap_priv(dec_priv), .trap_illegal(dec_ill)
    );

    assign trapped = dec_priv || dec_ill;

    srg_wpipe #(.DEPTH(DELAY), .IDX_W(IDX_W), .DW(DATA_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .advance(issue),
        .push(dec_wr && !trapped), .push_tgt(dec_tgt),
        .push_idx(asr_idx), .push_data(src_a ^ src_b),
        .commit(cm_en), .commit_tgt(cm_tgt), .commit_idx(cm_idx),
        .commit_data(cm_data), .stage_valid(pend_v)
    );

    srg_bank #(.IDX_W(IDX_W), .NUM_ASR(NUM_ASR), .DW(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cm_en), .wr_tgt(cm_tgt),
        .wr_idx(cm_idx), .wr_data(cm_data), .rd_tgt(dec_tgt),
        .rd_idx(asr_idx), .rd_data(bank_rd)
    );

    // Register read results and trap flags for the cycle after issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data      <= '0;
            rd_valid     <= 1'b0;
            trap_priv    <= 1'b0;
            trap_illegal <= 1'b0;
        end else begin
            rd_valid     <= issue && dec_rd && !trapped;
            rd_data      <= (issue && dec_rd && !trapped) ? bank_rd : '0;
            trap_priv    <= issue && dec_priv;
            trap_illegal <= issue && dec_ill;
        end
    end

    assert_traps_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_priv && trap_illegal));

    assert_y_never_privileged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op == OP_RD_Y || op == OP_WR_Y) |=> !trap_priv);

    assert_unimp_traps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op == OP_UNIMP |=> trap_illegal);

    assert_trap_not_queued_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue && trapped |=> !pend_v[0] && !rd_valid);

    assert_commit_needs_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |-> issue);

endmodule

// File: tb/test_state_reg_unit.sv
module test_state_reg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = '0;
    logic [4:0]  asr_idx = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        supervisor = 1'b1;
    logic [31:0] rd_data;
    logic        rd_valid, trap_priv, trap_illegal;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of committed registers and the three pending slots.
    logic [31:0] m_reg [8];   // 0 Y,1 PSR,2 WIM,3 TBR,4..7 ASR0..3
    logic        p_v [3];
    int          p_slot [3];
    logic [31:0] p_d [3];

    state_reg_unit i_state_reg_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .asr_idx(asr_idx),
        .src_a(src_a), .src_b(src_b), .supervisor(supervisor),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .trap_priv(trap_priv), .trap_illegal(trap_illegal)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) m_reg[k] = '0;
        m_reg[1] = 32'h0000_0080;
        for (int k = 0; k < 3; k++) begin p_v[k] = 0; p_slot[k] = 0; p_d[k] = '0; end
    endtask

    // Issue one operation, check its results against the model, update model.
    task automatic do_op(input logic [3:0] o, input logic [4:0] ix,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic sup, input string tag);
        logic [2:0] sel;
        logic nop, ill, prv, rd, wr;
        int slot;
        logic [31:0] exp_rd;
        sel  = o[2:0];
        nop  = (o == 4'd0);
        ill  = !nop && (sel == 3'd0 || sel > 3'd5 || (sel == 3'd5 && ix >= 5'd4));
        prv  = !nop && !ill && !sup && sel != 3'd1;
        rd   = !nop && !ill && !prv && !o[3];
        wr   = !nop && !ill && !prv && o[3];
        slot = (sel == 3'd5) ? 4 + int'(ix[1:0]) : int'(sel) - 1;
        exp_rd = rd ? m_reg[slot] : 32'h0;
        op = o; asr_idx = ix; src_a = a; src_b = b; supervisor = sup; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        chk({tag, " trap_illegal R5 R7 R10"}, {31'b0, trap_illegal}, {31'b0, ill});
        chk({tag, " trap_priv R4 R10"}, {31'b0, trap_priv}, {31'b0, prv});
        chk({tag, " rd_valid R6 R8"}, {31'b0, rd_valid}, {31'b0, rd});
        chk({tag, " rd_data R6 R3"}, rd_data, exp_rd);
        if (p_v[2]) m_reg[p_slot[2]] = p_d[2];
        p_v[2] = p_v[1]; p_slot[2] = p_slot[1]; p_d[2] = p_d[1];
        p_v[1] = p_v[0]; p_slot[1] = p_slot[0]; p_d[1] = p_d[0];
        p_v[0] = wr; p_slot[0] = slot; p_d[0] = a ^ b;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            issue = 1'b0;
            @(negedge clk);
            chk("idle outputs R6", {29'b0, rd_valid, trap_priv, trap_illegal}, 32'h0);
        end
    endtask

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset values of every register.
        for (int t = 1; t <= 5; t++) do_op(4'(t), 5'd3, '0, '0, 1'b1, "reset value R9");
        chk("R9 PSR explicit", m_reg[1], 32'h80);

        // R1 R2: explicit delay edge on Y with constants.
        do_op(4'd9, 5'd0, 32'hF0F0_1234, 32'h0FF0_1111, 1'b0, "R1 write Y");
        do_op(4'd1, 5'd0, '0, '0, 1'b0, "R2 read N+1");
        chk("R2 old at N+1", rd_data, 32'h0);
        idle(3);
        do_op(4'd1, 5'd0, '0, '0, 1'b0, "R2 read N+2");
        chk("R2 old after gaps", rd_data, 32'h0);
        do_op(4'd0, 5'd0, '0, '0, 1'b0, "R11 nop N+3");
        do_op(4'd1, 5'd0, '0, '0, 1'b0, "R2 read N+4");
        chk("R1 R2 new value", rd_data, 32'hFF00_0325);

        // R8: trapped user write between pending writes.
        do_op(4'd10, 5'd0, 32'h1, 32'h2, 1'b1, "R8 psr write a");
        do_op(4'd10, 5'd0, 32'hDEAD, 32'h0, 1'b0, "R8 trapped write");
        do_op(4'd15, 5'd0, 32'h5, 32'h0, 1'b1, "R8 unimp");
        do_op(4'd2, 5'd0, '0, '0, 1'b1, "R8 read before commit");
        do_op(4'd2, 5'd0, '0, '0, 1'b1, "R8 read after");
        chk("R8 psr value", m_reg[1], 32'h3);

        // Sweep: all opcodes, both modes, in- and out-of-range indices.
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < 16; o++)
                for (int j = 0; j < 6; j++) begin
                    logic [4:0] ix;
                    ix = (j < 4) ? 5'(j) : (j == 4 ? 5'd4 : 5'd31);
                    do_op(4'(o), ix, 32'h0101_0101 * 32'(o + 1) + 32'(j),
                          32'hA5A5_0000 ^ (32'(s) << 20) ^ 32'(j << 8), s[0], "sweep R3");
                    if (j == 2) idle(1);
                end
        // Drain pending writes and read every register back in supervisor mode.
        for (int k = 0; k < 3; k++) do_op(4'd0, 5'd0, '0, '0, 1'b0, "drain R11");
        for (int t = 1; t <= 5; t++)
            for (int j = 0; j < 4; j++)
                do_op(4'(t), 5'(j), '0, '0, 1'b1, "readback R3 R1");

        // R9: reset with writes in flight clears them.
        do_op(4'd11, 5'd0, 32'h77, 32'h0, 1'b1, "R9 pre-reset write");
        do_op(4'd13, 5'd1, 32'h55, 32'h0, 1'b1, "R9 pre-reset asr");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        for (int k = 0; k < 4; k++) do_op(4'd0, 5'd0, '0, '0, 1'b1, "R9 nop");
        do_op(4'd3, 5'd0, '0, '0, 1'b1, "R9 wim after reset");
        chk("R9 wim cleared", rd_data, 32'h0);
        do_op(4'd5, 5'd1, '0, '0, 1'b1, "R9 asr1 after reset");
        chk("R9 asr cleared", rd_data, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule